// File: doc/BRIEF.md
# Cache Line Refill Controller with Selectable Memory Organization

This block fetches one four-word cache line from a modeled main memory and hands the words to the cache over a result bus. The memory behind it can be built three ways, chosen at elaboration time. The narrow build has a single bank that is one word wide and a one-word bus. The wide build has a single bank that is one line wide and a line-wide bus. The interleaved build has four one-word banks, all read at the same time, with a one-word bus. In every build the clock costs are fixed: one clock carries the line address to memory, and this happens once per refill. Each memory access takes fifteen clocks, however wide the bank is. Each busload takes one clock.

The cache raises `req` for a clock with the line number on `req_line`. The block then returns the data. Each clock that carries data raises `rd_valid`. `rd_mask` shows which word lanes of `rd_data` hold data, and `rd_idx` gives the offset of the word being moved. `rd_done` marks the last busload of the refill. The storage is a fixed computed pattern, so any line can be checked without a loading path.

Top module: `line_refill`

## Requirements
- R1: After reset, and at any time no busload is in progress, `rd_valid`, `rd_done`, `rd_mask` and `rd_data` are all zero.
- R2: Narrow build. Cycle 1 is the clock after the edge that accepts the request. Word k (k = 0..3) appears alone in cycle 17 + 16·k, and `rd_done` is high in cycle 65. No data moves in any other cycle.
- R3: Wide build. All four lanes carry data in one busload in cycle 17, with `rd_mask` = 4'b1111, `rd_idx` = 0 and `rd_done` high in that same cycle.
- R4: Interleaved build. The four words arrive in the consecutive cycles 17, 18, 19 and 20, and `rd_done` is high in cycle 20.
- R5: Interleaved build. Word offset k of the line is read from bank k (the word address modulo 4). Words are returned in ascending offset order, so `rd_idx` steps 0, 1, 2, 3.
- R6: Lane j of `rd_data` (bits 32·j+31 down to 32·j) holds the memory word at word address A = 4·line + j. The word stored at address A is ((A × 0x9E3779B1) XOR 0x5A5A0000) mod 2^32.
- R7: `rd_done` is high for exactly one cycle per refill. That cycle is the cycle of the final busload.
- R8: A `req` raised while a refill is in progress is ignored, whatever value is on `req_line`. The refill's timing and data are unchanged, and no further transfer follows its `rd_done`.
- R9: In the narrow and interleaved builds, each busload sets exactly one `rd_mask` bit, bit `rd_idx`. Lanes whose mask bit is clear read zero.
- R10: A request raised in the cycle that follows `rd_done` is accepted. Its refill keeps the same cycle costs as the first refill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Refill request, sampled while idle |
| req_line | input | ADDR_W-2 (10) | Line number to refill |
| rd_valid | output | 1 | A busload is on `rd_data` this cycle |
| rd_idx | output | 2 | Word offset of the busload (0 for the wide build) |
| rd_mask | output | 4 | Lanes of `rd_data` that carry data |
| rd_data | output | 4·DATA_W (128) | Word lanes; lane j holds word offset j |
| rd_done | output | 1 | Final busload of the refill |

## Verification
The bound properties assume only that reset is applied before the first refill. They make no assumption about `req` or `req_line`, because the block must tolerate a request at any time. The bench measures the wait for each build and checks that it is 65, 17 or 20 clocks. It raises `req` with a different line in the middle of a refill, so the property that no data moves after `rd_done` is exercised under that traffic. The bench drives `req` and `req_line` only at the falling clock edge and samples at the falling edge. Every value it checks is therefore settled.

// File: rtl/line_refill_pkg.sv
package line_refill_pkg;

    // Memory organization behind the refill bus
    typedef enum logic [1:0] {
        ORG_NARROW      = 2'd0,
        ORG_WIDE        = 2'd1,
        ORG_INTERLEAVED = 2'd2
    } org_e;

    // Controller phases
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WAIT = 2'd2,
        ST_XFER = 2'd3
    } phase_e;

    localparam int unsigned WORD_MUL = 32'h9E3779B1;
    localparam logic [31:0] WORD_XOR = 32'h5A5A0000;

    // Content of the modeled storage at a word address
    function automatic logic [31:0] word_value(input logic [31:0] addr);
        logic [31:0] prod;
        prod = addr * WORD_MUL;
        return prod ^ WORD_XOR;
    endfunction

    // Total refill cost in clocks for an organization
    function automatic int unsigned refill_cost(input org_e org, input int unsigned words,
                                                input int unsigned lat);
        case (org)
            ORG_NARROW: return 1 + words * (lat + 1);
            ORG_WIDE:   return 1 + lat + 1;
            default:    return 1 + lat + words;
        endcase
    endfunction

endpackage

// File: rtl/refill_bank.sv
module refill_bank
    import line_refill_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANES  = 1,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned LAT    = 15
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [ADDR_W-1:0]         addr,
    output logic                      ready,
    output logic [LANES*DATA_W-1:0]   data
);

    localparam int unsigned CNT_W = $clog2(LAT + 1);

    logic [CNT_W-1:0]        cnt_q;
    logic [ADDR_W-1:0]       addr_q;
    logic [LANES*DATA_W-1:0] fetch;

    // Words of one access, consecutive addresses from addr_q
    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            fetch[j*DATA_W +: DATA_W] =
                DATA_W'(word_value(32'(addr_q) + 32'(j)));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            addr_q <= '0;
            ready  <= 1'b0;
            data   <= '0;
        end else begin
            ready <= 1'b0;
            if (start) begin
                addr_q <= addr;
                cnt_q  <= CNT_W'(LAT);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    ready <= 1'b1;
                    data  <= fetch;
                end
            end
        end
    end

endmodule

// File: rtl/refill_fsm.sv
module refill_fsm
    import line_refill_pkg::*;
#(
    parameter org_e        ORG     = ORG_INTERLEAVED,
    parameter int unsigned WORDS   = 4,
    parameter int unsigned LINE_AW = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req,
    input  logic [LINE_AW-1:0]         req_line,
    input  logic                       bank_ready,
    output logic                       bank_start,
    output logic [$clog2(WORDS)-1:0]   start_off,
    output logic [LINE_AW-1:0]         line_q,
    output logic                       xfer_valid,
    output logic [$clog2(WORDS)-1:0]   xfer_idx,
    output logic                       done
);

    localparam int unsigned OFF_W = $clog2(WORDS);
    localparam logic [OFF_W-1:0] LAST = OFF_W'(WORDS - 1);

    phase_e           state_q;
    logic [OFF_W-1:0] idx_q;

    always_comb begin
        bank_start = 1'b0;
        start_off  = '0;
        xfer_valid = 1'b0;
        xfer_idx   = idx_q;
        done       = 1'b0;
        case (state_q)
            ST_ADDR: begin
                bank_start = 1'b1;
                start_off  = idx_q;
            end
            ST_WAIT: begin
                if (bank_ready) begin
                    xfer_valid = 1'b1;
                    if (ORG == ORG_WIDE) begin
                        done = 1'b1;
                    end else if (ORG == ORG_NARROW) begin
                        if (idx_q == LAST) begin
                            done = 1'b1;
                        end else begin
                            bank_start = 1'b1;
                            start_off  = idx_q + 1'b1;
                        end
                    end
                end
            end
            ST_XFER: begin
                xfer_valid = 1'b1;
                done       = (idx_q == LAST);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            line_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req) begin
                        line_q  <= req_line;
                        idx_q   <= '0;
                        state_q <= ST_ADDR;
                    end
                end
                ST_ADDR: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (bank_ready) begin
                        if (ORG == ORG_WIDE) begin
                            state_q <= ST_IDLE;
                        end else if (ORG == ORG_NARROW) begin
                            if (idx_q == LAST) state_q <= ST_IDLE;
                            else idx_q <= idx_q + 1'b1;
                        end else begin
                            idx_q   <= OFF_W'(1);
                            state_q <= ST_XFER;
                        end
                    end
                end
                ST_XFER: begin
                    if (idx_q == LAST) state_q <= ST_IDLE;
                    else idx_q <= idx_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/line_refill.sv
module line_refill
    import line_refill_pkg::*;
#(
    parameter org_e        ORG    = ORG_INTERLEAVED,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WORDS  = 4,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned LAT    = 15
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req,
    input  logic [ADDR_W-$clog2(WORDS)-1:0] req_line,
    output logic                        rd_valid,
    output logic [$clog2(WORDS)-1:0]    rd_idx,
    output logic [WORDS-1:0]            rd_mask,
    output logic [WORDS*DATA_W-1:0]     rd_data,
    output logic                        rd_done
);

    localparam int unsigned OFF_W      = $clog2(WORDS);
    localparam int unsigned LINE_AW    = ADDR_W - OFF_W;
    localparam int unsigned NBANK      = (ORG == ORG_INTERLEAVED) ? WORDS : 1;
    localparam int unsigned BANK_LANES = (ORG == ORG_WIDE) ? WORDS : 1;
    localparam int unsigned BANK_DW    = BANK_LANES * DATA_W;

    logic                 bank_start;
    logic [OFF_W-1:0]     start_off;
    logic [LINE_AW-1:0]   line_q;
    logic                 xfer_valid;
    logic [OFF_W-1:0]     xfer_idx;
    logic                 xfer_done;
    logic [NBANK-1:0]     ready_vec;
    logic [BANK_DW-1:0]   bank_data [NBANK];
    logic [DATA_W-1:0]    lane_word [WORDS];

    refill_fsm #(
        .ORG     (ORG),
        .WORDS   (WORDS),
        .LINE_AW (LINE_AW)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .req_line   (req_line),
        .bank_ready (&ready_vec),
        .bank_start (bank_start),
        .start_off  (start_off),
        .line_q     (line_q),
        .xfer_valid (xfer_valid),
        .xfer_idx   (xfer_idx),
        .done       (xfer_done)
    );

    // Bank k of an interleaved build holds word offsets equal to k mod NBANK
    for (genvar k = 0; k < NBANK; k++) begin : g_bank
        logic [OFF_W-1:0] off;
        assign off = OFF_W'(k) + start_off;
        refill_bank #(
            .DATA_W (DATA_W),
            .LANES  (BANK_LANES),
            .ADDR_W (ADDR_W),
            .LAT    (LAT)
        ) u_bank (
            .clk   (clk),
            .rst   (rst),
            .start (bank_start),
            .addr  ({line_q, off}),
            .ready (ready_vec[k]),
            .data  (bank_data[k])
        );
    end

    for (genvar i = 0; i < WORDS; i++) begin : g_lane
        if (ORG == ORG_WIDE) begin : g_wide
            assign lane_word[i] = bank_data[0][i*DATA_W +: DATA_W];
        end else if (ORG == ORG_INTERLEAVED) begin : g_ilv
            assign lane_word[i] = bank_data[i][DATA_W-1:0];
        end else begin : g_nar
            assign lane_word[i] = bank_data[0][DATA_W-1:0];
        end
        assign rd_data[i*DATA_W +: DATA_W] = rd_mask[i] ? lane_word[i] : '0;
    end

    always_comb begin
        if (!xfer_valid)          rd_mask = '0;
        else if (ORG == ORG_WIDE) rd_mask = '1;
        else                      rd_mask = WORDS'(1) << xfer_idx;
    end

    assign rd_valid = xfer_valid;
    assign rd_idx   = xfer_idx;
    assign rd_done  = xfer_done;

endmodule

// File: rtl/line_refill_chk.sv
module line_refill_chk
    import line_refill_pkg::*;
#(
    parameter org_e        ORG   = ORG_INTERLEAVED,
    parameter int unsigned WORDS = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     rd_valid,
    input logic [$clog2(WORDS)-1:0] rd_idx,
    input logic [WORDS-1:0]         rd_mask,
    input logic                     rd_done
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_mask == '0 && !rd_done));

    // R7
    done_with_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> rd_valid);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> !rd_done);

    // R8
    quiet_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> !rd_valid);

    if (ORG == ORG_WIDE) begin : g_wide
        // R3
        full_busload_chk: assert property (@(posedge clk) disable iff (rst)
            rd_valid |-> (rd_mask == '1 && rd_done && rd_idx == '0));
    end else begin : g_word
        // R9
        single_lane_chk: assert property (@(posedge clk) disable iff (rst)
            rd_valid |-> (rd_mask == (WORDS'(1) << rd_idx)));
    end

    if (ORG == ORG_NARROW) begin : g_nar
        // R2
        narrow_gap_chk: assert property (@(posedge clk) disable iff (rst)
            (rd_valid && !rd_done) |=> !rd_valid);
    end

    if (ORG == ORG_INTERLEAVED) begin : g_ilv
        // R4
        burst_run_chk: assert property (@(posedge clk) disable iff (rst)
            (rd_valid && !rd_done) |=> rd_valid);
        // R5
        ascending_idx_chk: assert property (@(posedge clk) disable iff (rst)
            (rd_valid && !rd_done) |=> (rd_idx == $past(rd_idx) + 1'b1));
    end

endmodule

bind line_refill line_refill_chk #(
    .ORG   (ORG),
    .WORDS (WORDS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_valid (rd_valid),
    .rd_idx   (rd_idx),
    .rd_mask  (rd_mask),
    .rd_done  (rd_done)
);

// File: tb/line_refill_bench.sv
module line_refill_bench;
    import line_refill_pkg::*;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned WORDS   = 4;
    localparam int unsigned ADDR_W  = 12;
    localparam int unsigned LAT     = 15;
    localparam int unsigned OFF_W   = 2;
    localparam int unsigned LINE_AW = ADDR_W - OFF_W;
    localparam int unsigned LINE_W  = WORDS * DATA_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic               req     [3];
    logic [LINE_AW-1:0] line_in [3];
    logic               valid   [3];
    logic [OFF_W-1:0]   idx     [3];
    logic [WORDS-1:0]   mask    [3];
    logic [LINE_W-1:0]  data    [3];
    logic               done    [3];

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    line_refill #(.ORG(ORG_NARROW)) u_line_refill (
        .clk(clk), .rst(rst), .req(req[0]), .req_line(line_in[0]),
        .rd_valid(valid[0]), .rd_idx(idx[0]), .rd_mask(mask[0]),
        .rd_data(data[0]), .rd_done(done[0]));

    line_refill #(.ORG(ORG_WIDE)) u_line_refill_wide (
        .clk(clk), .rst(rst), .req(req[1]), .req_line(line_in[1]),
        .rd_valid(valid[1]), .rd_idx(idx[1]), .rd_mask(mask[1]),
        .rd_data(data[1]), .rd_done(done[1]));

    line_refill #(.ORG(ORG_INTERLEAVED)) u_line_refill_ilv (
        .clk(clk), .rst(rst), .req(req[2]), .req_line(line_in[2]),
        .rd_valid(valid[2]), .rd_idx(idx[2]), .rd_mask(mask[2]),
        .rd_data(data[2]), .rd_done(done[2]));

    task automatic check(input bit ok, input string rq, input string msg);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", rq, msg);
        end
    endtask

    function automatic logic [31:0] model_word(input int unsigned a);
        logic [31:0] p;
        p = 32'(a) * 32'h9E3779B1;
        return p ^ 32'h5A5A0000;
    endfunction

    function automatic logic [LINE_W-1:0] model_lanes(input logic [LINE_AW-1:0] ln,
                                                     input logic [WORDS-1:0] m);
        logic [LINE_W-1:0] v;
        v = '0;
        for (int j = 0; j < WORDS; j++)
            if (m[j]) v[j*DATA_W +: DATA_W] = model_word(int'(ln) * WORDS + j);
        return v;
    endfunction

    function automatic string mode_tag(input int m);
        if (m == 0) return "R2";
        if (m == 1) return "R3";
        return "R4";
    endfunction

    // One refill on build m. Starts at a falling edge and ends at the falling edge of the done cycle.
    task automatic run_refill(input int m, input logic [LINE_AW-1:0] ln,
                              input bit poke, input bit tail);
        int cyc;
        int beats;
        int exp_total;
        int exp_beats;
        int exp_cyc;
        logic [WORDS-1:0] exp_mask;
        exp_total = (m == 0) ? 1 + WORDS * (LAT + 1) : (m == 1) ? LAT + 2 : 1 + LAT + WORDS;
        exp_beats = (m == 1) ? 1 : WORDS;
        line_in[m] = ln;
        req[m] = 1'b1;
        @(posedge clk);
        cyc = 0;
        beats = 0;
        while (cyc < 200) begin
            @(negedge clk);
            cyc++;
            req[m] = 1'b0;
            if (poke && (cyc == 3 || cyc == 30)) begin
                // R8: stray request with another line while busy
                req[m] = 1'b1;
                line_in[m] = ~ln;
            end
            if (valid[m]) begin
                exp_cyc  = (m == 0) ? 1 + (beats + 1) * (LAT + 1) :
                           (m == 1) ? LAT + 2 : LAT + 2 + beats;
                exp_mask = (m == 1) ? '1 : WORDS'(1) << beats;
                check(cyc == exp_cyc, mode_tag(m),
                      $sformatf("build %0d beat %0d cycle %0d expected %0d", m, beats, cyc, exp_cyc));
                check(mask[m] == exp_mask && idx[m] == ((m == 1) ? 2'd0 : OFF_W'(beats)),
                      (m == 2) ? "R5" : "R9",
                      $sformatf("build %0d mask %b idx %0d expected %b idx %0d",
                                m, mask[m], idx[m], exp_mask, (m == 1) ? 0 : beats));
                check(data[m] == model_lanes(ln, exp_mask), "R6",
                      $sformatf("build %0d data %h expected %h", m, data[m], model_lanes(ln, exp_mask)));
                check(done[m] == (beats == exp_beats - 1), "R7",
                      $sformatf("build %0d beat %0d done %0b expected %0b",
                                m, beats, done[m], beats == exp_beats - 1));
                beats++;
            end else begin
                check(!done[m] && mask[m] == '0 && data[m] == '0, "R1",
                      $sformatf("build %0d idle cycle %0d done %0b mask %b", m, cyc, done[m], mask[m]));
            end
            if (done[m]) break;
        end
        check(cyc == exp_total, mode_tag(m),
              $sformatf("build %0d refill took %0d cycles expected %0d", m, cyc, exp_total));
        check(beats == exp_beats, mode_tag(m),
              $sformatf("build %0d busloads %0d expected %0d", m, beats, exp_beats));
        req[m] = 1'b0;
        if (tail) begin
            for (int t = 0; t < 6; t++) begin
                @(negedge clk);
                check(!valid[m] && !done[m] && data[m] == '0, "R8",
                      $sformatf("build %0d after done valid %0b done %0b", m, valid[m], done[m]));
            end
        end
    endtask

    task automatic t_reset;
        for (int m = 0; m < 3; m++)
            check(!valid[m] && !done[m] && mask[m] == '0 && data[m] == '0, "R1",
                  $sformatf("build %0d after reset valid %0b done %0b mask %b expected 0 0 0000",
                            m, valid[m], done[m], mask[m]));
    endtask

    task automatic t_narrow;
        run_refill(0, 10'h000, 1'b0, 1'b1);
        run_refill(0, 10'h3FF, 1'b0, 1'b1);
    endtask

    task automatic t_wide;
        run_refill(1, 10'h123, 1'b0, 1'b1);
        run_refill(1, 10'h3FF, 1'b0, 1'b1);
    endtask

    task automatic t_interleaved;
        run_refill(2, 10'h2A5, 1'b0, 1'b1);
        run_refill(2, 10'h001, 1'b0, 1'b1);
    endtask

    task automatic t_busy_request;
        // R8: stray requests during each build's refill
        for (int m = 0; m < 3; m++) run_refill(m, 10'h155, 1'b1, 1'b1);
    endtask

    task automatic t_back_to_back;
        // R10: next request raised in the cycle after done
        run_refill(2, 10'h010, 1'b0, 1'b0);
        @(negedge clk);
        run_refill(2, 10'h011, 1'b0, 1'b1);
        run_refill(0, 10'h020, 1'b0, 1'b0);
        @(negedge clk);
        run_refill(0, 10'h021, 1'b0, 1'b1);
    endtask

    initial begin
        for (int m = 0; m < 3; m++) begin
            req[m] = 1'b0;
            line_in[m] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_narrow();
        t_wide();
        t_interleaved();
        t_busy_request();
        t_back_to_back();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule